// File: doc/BRIEF.md
# Thread Branch Divergence Controller

This block steers a 16-pixel thread through dynamic branches. All pixels of a thread share one instruction stream, so the controller keeps a lane mask that says which pixels currently commit results. When the sequencer issues a branch, it hands over one condition bit per pixel. The controller looks only at the lanes that are live in the current mask. If those lanes all agree, it runs only the chosen path and sends the program counter past the other one. If they disagree, it runs the taken path under the lanes whose condition is set and then the other path under the remaining live lanes. At the join point it restores the mask that was live before the branch.

The sequencer reports three markers: a branch, the end of the taken path ("else"), and the join. Redirect targets always point just past a marker, so a skipped path never emits its own markers. Each branch saves its context on a small stack, which lets branches nest. Using the stack beyond its depth, or popping an empty stack, raises a sticky error that also tells the thread to terminate. A thread start reloads the mask and clears both the stack and the error. The controller runs beside the arithmetic and texture pipes and never stalls them. Each decision shows up on the registered outputs one clock after the event.

Top module: `bdc_ctrl`

## Requirements
- R1: One clock after `thr_start`, `act_mask` equals `thr_mask`, `err` and `abort` are 0 and `redir_vld` is 0; the stack is emptied.
- R2: A branch (op code 1) whose live lanes disagree (mask&cond and mask&~cond both non-zero) sets `act_mask` to mask&cond on the next clock with no redirect.
- R3: A branch where every live lane has its condition set keeps `act_mask` and does not redirect; the following else marker (op code 2) pops the entry, restores the saved mask and redirects to that branch's `join_pc`.
- R4: A branch where no live lane has its condition set redirects to `else_pc` and keeps `act_mask` (equal to mask&~cond).
- R5: Condition bits of lanes that are 0 in `act_mask` never affect the decision.
- R6: A branch issued with an all-zero `act_mask` redirects to `join_pc`, pushes nothing and leaves the mask at zero.
- R7: After a divergent branch, the else marker sets `act_mask` to the saved mask AND NOT cond, with no redirect.
- R8: A join marker (op code 3) pops the innermost entry and restores the mask that was live at its branch, with no redirect.
- R9: Up to DEPTH (4) branches nest; the joins restore masks in last-in first-out order.
- R10: A branch that needs a stack entry while DEPTH entries are held sets `err` and `abort`. These stay set until `thr_start`, and while they are set, `act_mask` holds and op codes are ignored.
- R11: An else or join marker with an empty stack sets `err` and `abort`.
- R12: `redir_vld` is high only in the clock after an event that redirects (R3 skip, R4, R6); `redir_pc` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_start | input | 1 | Begin a new thread, load `thr_mask` |
| thr_mask | input | 16 | Initial lane mask of the thread |
| op | input | 2 | 0 none, 1 branch, 2 else marker, 3 join marker |
| cond | input | 16 | Per-lane branch condition |
| else_pc | input | PCW | First instruction of the not-taken path |
| join_pc | input | PCW | First instruction after the join marker |
| act_mask | output | 16 | Lanes that currently commit results |
| redir_vld | output | 1 | Program counter must jump this cycle |
| redir_pc | output | PCW | Jump target |
| err | output | 1 | Sticky stack overflow or underflow |
| abort | output | 1 | Thread must finish |

## Verification
On every clock, the assertions check the following. A divergent branch splits the mask into its taken lanes with no redirect. An overflow or underflow always raises the error. The error stays set and freezes the mask until a thread start. A start loads its mask cleanly. The stack never holds more than DEPTH entries. The bench's scenarios are needed to show the uniform-path skips, with their exact redirect targets. They also show the second half of a split running under the complementary lanes, LIFO restoration across four nesting levels, and inactive lanes carrying contrary condition bits without changing the outcome. A reference model checks long random op sequences to cover orderings that the directed cases miss.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int unsigned LANES = 16;
  typedef logic [LANES-1:0] lane_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_BRANCH = 2'd1,
    OP_ELSE   = 2'd2,
    OP_JOIN   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    DEC_SPLIT = 2'd0,
    DEC_TAKEN = 2'd1,
    DEC_FALL  = 2'd2,
    DEC_EMPTY = 2'd3
  } dec_e;

  function automatic lane_t lanes_taken(lane_t live, lane_t c);
    return live & c;
  endfunction

  function automatic lane_t lanes_fall(lane_t live, lane_t c);
    return live & ~c;
  endfunction

  function automatic dec_e classify(lane_t t, lane_t f);
    if (t != '0 && f != '0) return DEC_SPLIT;
    else if (t != '0)       return DEC_TAKEN;
    else if (f != '0)       return DEC_FALL;
    else                    return DEC_EMPTY;
  endfunction
endpackage

// File: rtl/bdc_split.sv
module bdc_split
  import bdc_pkg::*;
(
  input  lane_t live,
  input  lane_t cond,
  output lane_t tk,
  output lane_t ft,
  output dec_e  dec
);
  always_comb begin
    tk  = lanes_taken(live, cond);
    ft  = lanes_fall(live, cond);
    dec = classify(tk, ft);
  end
endmodule

// File: rtl/bdc_stack.sv
module bdc_stack #(
  parameter int unsigned W     = 44,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          wr_top,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  top_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx, push_idx;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign count    = cnt_q;
  assign top_idx  = IW'(cnt_q - CW'(1));
  assign push_idx = IW'(cnt_q);
  assign top_data = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (push && !full)     cnt_q <= cnt_q + CW'(1);
    else if (pop && !empty)     cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!clear && push && !full)          mem[push_idx] <= push_data;
    else if (!clear && wr_top && !empty)  mem[top_idx]  <= wr_data;
  end
endmodule

// File: rtl/bdc_ctrl.sv
module bdc_ctrl
  import bdc_pkg::*;
#(
  parameter int unsigned PCW   = 12,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned EW   = 2 * LANES + PCW,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_start,
  input  logic [LANES-1:0] thr_mask,
  input  logic [1:0]       op,
  input  logic [LANES-1:0] cond,
  input  logic [PCW-1:0]   else_pc,
  input  logic [PCW-1:0]   join_pc,
  output logic [LANES-1:0] act_mask,
  output logic             redir_vld,
  output logic [PCW-1:0]   redir_pc,
  output logic             err,
  output logic             abort
);
  lane_t          act_q;
  logic           rv_q, err_q;
  logic [PCW-1:0] rpc_q;

  op_e   op_i;
  lane_t tk, ft;
  dec_e  dec;

  logic [EW-1:0]  ent_push, ent_top, ent_wr;
  lane_t          top_saved, top_pend, pend_w;
  logic [PCW-1:0] top_join;
  logic           stk_empty, stk_full;
  logic [CW-1:0]  stk_depth;

  // named events, also used by the checker
  logic live, is_br, is_else, is_join;
  logic need_push, ev_push, ev_diverge, ev_ovf, ev_unf;
  logic ev_else_split, ev_else_skip, ev_join_pop, ev_pop;

  assign op_i = op_e'(op);

  bdc_split u_split (
    .live (act_q),
    .cond (cond),
    .tk   (tk),
    .ft   (ft),
    .dec  (dec)
  );

  assign live    = !err_q && !thr_start;
  assign is_br   = live && (op_i == OP_BRANCH);
  assign is_else = live && (op_i == OP_ELSE);
  assign is_join = live && (op_i == OP_JOIN);

  assign pend_w    = (dec == DEC_SPLIT) ? ft : '0;
  assign ent_push  = {act_q, pend_w, join_pc};
  assign top_saved = ent_top[EW-1 -: LANES];
  assign top_pend  = ent_top[PCW+LANES-1 -: LANES];
  assign top_join  = ent_top[PCW-1:0];
  assign ent_wr    = {top_saved, {LANES{1'b0}}, top_join};

  assign need_push     = is_br && (dec != DEC_EMPTY);
  assign ev_ovf        = need_push && stk_full;
  assign ev_push       = need_push && !stk_full;
  assign ev_diverge    = ev_push && (dec == DEC_SPLIT);
  assign ev_unf        = (is_else || is_join) && stk_empty;
  assign ev_else_split = is_else && !stk_empty && (top_pend != '0);
  assign ev_else_skip  = is_else && !stk_empty && (top_pend == '0);
  assign ev_join_pop   = is_join && !stk_empty;
  assign ev_pop        = ev_else_skip || ev_join_pop;

  bdc_stack #(.W(EW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (thr_start),
    .push      (ev_push),
    .push_data (ent_push),
    .pop       (ev_pop),
    .wr_top    (ev_else_split),
    .wr_data   (ent_wr),
    .top_data  (ent_top),
    .empty     (stk_empty),
    .full      (stk_full),
    .count     (stk_depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rv_q  <= 1'b0;
      rpc_q <= '0;
      err_q <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (thr_start) begin
        act_q <= thr_mask;
        err_q <= 1'b0;
      end else if (ev_ovf || ev_unf) begin
        err_q <= 1'b1;
      end else if (is_br) begin
        unique case (dec)
          DEC_SPLIT, DEC_TAKEN: act_q <= tk;
          DEC_FALL: begin
            act_q <= ft;
            rv_q  <= 1'b1;
            rpc_q <= else_pc;
          end
          DEC_EMPTY: begin
            rv_q  <= 1'b1;
            rpc_q <= join_pc;
          end
        endcase
      end else if (ev_else_split) begin
        act_q <= top_pend;
      end else if (ev_else_skip) begin
        act_q <= top_saved;
        rv_q  <= 1'b1;
        rpc_q <= top_join;
      end else if (ev_join_pop) begin
        act_q <= top_saved;
      end
    end
  end

  assign act_mask  = act_q;
  assign redir_vld = rv_q;
  assign redir_pc  = rpc_q;
  assign err       = err_q;
  assign abort     = err_q;
endmodule

// File: rtl/bdc_chk.sv
module bdc_chk #(
  parameter int unsigned LN    = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          thr_start,
  input logic [LN-1:0] thr_mask,
  input logic [LN-1:0] cond,
  input logic [LN-1:0] act_mask,
  input logic          redir_vld,
  input logic          err,
  input logic          abort,
  input logic          ev_diverge,
  input logic          ev_ovf,
  input logic          ev_unf,
  input logic [CW-1:0] stk_depth
);
  p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    thr_start |=> (act_mask == $past(thr_mask)) && !err && !redir_vld);

  p_split_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_diverge |=> (act_mask == ($past(act_mask) & $past(cond))) && !redir_vld);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= CW'(DEPTH));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> err && abort);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !thr_start) |=> err && $stable(act_mask) && !redir_vld);

  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> err && abort);
endmodule

bind bdc_ctrl bdc_chk #(.LN(bdc_pkg::LANES), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .thr_start  (thr_start),
  .thr_mask   (thr_mask),
  .cond       (cond),
  .act_mask   (act_mask),
  .redir_vld  (redir_vld),
  .err        (err),
  .abort      (abort),
  .ev_diverge (ev_diverge),
  .ev_ovf     (ev_ovf),
  .ev_unf     (ev_unf),
  .stk_depth  (stk_depth)
);

// File: tb/sim_bdc_ctrl.sv
`timescale 1ns/1ps
module sim_bdc_ctrl;
  localparam int PCW = 12;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_start = 1'b0;
  logic [15:0] thr_mask = '0, cond = '0;
  logic [1:0] op = 2'd0;
  logic [PCW-1:0] else_pc = '0, join_pc = '0;
  logic [15:0] act_mask;
  logic redir_vld, err, abort;
  logic [PCW-1:0] redir_pc;

  int checks = 0, fails = 0;

  // reference state
  logic [15:0] em;
  logic ee;
  logic erv;
  logic [PCW-1:0] erpc;
  logic [15:0] sv [DEPTH];
  logic [15:0] pd [DEPTH];
  logic [PCW-1:0] jn [DEPTH];
  int cnt;

  always #2.5 clk = ~clk;

  bdc_ctrl #(.PCW(PCW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_start(thr_start), .thr_mask(thr_mask),
    .op(op), .cond(cond), .else_pc(else_pc), .join_pc(join_pc),
    .act_mask(act_mask), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .err(err), .abort(abort)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic void model(input logic st, input logic [15:0] sm, input logic [1:0] o,
                                input logic [15:0] c, input logic [PCW-1:0] ep, input logic [PCW-1:0] jp);
    logic [15:0] on_lanes, off_lanes;
    erv = 1'b0;
    if (st) begin
      em = sm; ee = 1'b0; cnt = 0;
    end else if (!ee) begin
      on_lanes  = em & c;
      off_lanes = em & ~c;
      case (o)
        2'd1: begin
          if (em == 16'h0) begin erv = 1'b1; erpc = jp; end
          else if (cnt == DEPTH) ee = 1'b1;
          else begin
            sv[cnt] = em; jn[cnt] = jp;
            pd[cnt] = (on_lanes != 0 && off_lanes != 0) ? off_lanes : 16'h0;
            cnt++;
            if (on_lanes != 0) em = on_lanes;
            else begin erv = 1'b1; erpc = ep; end
          end
        end
        2'd2: begin
          if (cnt == 0) ee = 1'b1;
          else if (pd[cnt-1] != 0) begin em = pd[cnt-1]; pd[cnt-1] = 16'h0; end
          else begin cnt--; em = sv[cnt]; erv = 1'b1; erpc = jn[cnt]; end
        end
        2'd3: begin
          if (cnt == 0) ee = 1'b1;
          else begin cnt--; em = sv[cnt]; end
        end
        default: ;
      endcase
    end
  endfunction

  task automatic step(input string tag, input logic st, input logic [15:0] sm, input logic [1:0] o,
                      input logic [15:0] c, input logic [PCW-1:0] ep, input logic [PCW-1:0] jp);
    @(negedge clk);
    thr_start = st; thr_mask = sm; op = o; cond = c; else_pc = ep; join_pc = jp;
    model(st, sm, o, c, ep, jp);
    @(posedge clk);
    #1;
    chk(tag, "act_mask", 32'(act_mask), 32'(em));
    chk(tag, "redir_vld", 32'(redir_vld), 32'(erv));
    if (erv) chk(tag, "redir_pc", 32'(redir_pc), 32'(erpc));
    chk(tag, "err", 32'(err), 32'(ee));
    chk(tag, "abort", 32'(abort), 32'(ee));
  endtask

  function automatic string tag_of(input logic st, input logic [1:0] o);
    if (st) return "R1";
    case (o)
      2'd1: return "R2";
      2'd2: return "R7";
      2'd3: return "R8";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    em = '0; ee = 0; erv = 0; erpc = '0; cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset act_mask", 32'(act_mask), 32'h0);
    chk("R1", "reset err", 32'(err), 32'h0);
    chk("R12", "reset redir_vld", 32'(redir_vld), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 start
    step("R1", 1, 16'hFFFF, 0, 0, 0, 0);
    // R2 divergent, R7 else half, R8 join
    step("R2", 0, 0, 1, 16'h00F0, 12'h010, 12'h020);
    step("R7", 0, 0, 2, 0, 0, 0);
    step("R8", 0, 0, 3, 0, 0, 0);
    // R3 uniform taken then skip of else path
    step("R3", 0, 0, 1, 16'hFFFF, 12'h030, 12'h040);
    step("R3", 0, 0, 2, 0, 0, 0);
    // R4 uniform fall-through
    step("R4", 0, 0, 1, 16'h0000, 12'h050, 12'h060);
    step("R8", 0, 0, 3, 0, 0, 0);
    // R5 inactive lanes carry contrary bits
    step("R1", 1, 16'h00FF, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 16'hFF00, 12'h070, 12'h080);
    step("R8", 0, 0, 3, 0, 0, 0);
    step("R5", 0, 0, 1, 16'h00FF, 12'h071, 12'h081);
    step("R3", 0, 0, 2, 0, 0, 0);
    // R6 empty mask
    step("R1", 1, 16'h0000, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 16'hFFFF, 12'h090, 12'h0A0);
    step("R11", 0, 0, 3, 0, 0, 0);
    // R9 four-level nesting, R10 overflow
    step("R1", 1, 16'hFFFF, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 16'h7FFF, 12'h100, 12'h101);
    step("R9", 0, 0, 1, 16'h3FFF, 12'h102, 12'h103);
    step("R9", 0, 0, 1, 16'h1FFF, 12'h104, 12'h105);
    step("R9", 0, 0, 1, 16'h0FFF, 12'h106, 12'h107);
    step("R10", 0, 0, 1, 16'h00FF, 12'h108, 12'h109);
    step("R10", 0, 0, 3, 0, 0, 0);
    step("R10", 0, 0, 1, 16'h0001, 12'h10A, 12'h10B);
    // R9 LIFO restore
    step("R1", 1, 16'hFFFF, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 16'h0FF0, 12'h110, 12'h111);
    step("R9", 0, 0, 1, 16'h03C0, 12'h112, 12'h113);
    step("R9", 0, 0, 3, 0, 0, 0);
    step("R9", 0, 0, 3, 0, 0, 0);
    // R11 else on empty
    step("R11", 0, 0, 2, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic st;
      logic [1:0] o;
      logic [15:0] sm, c;
      st = ($urandom_range(0, 29) == 0);
      sm = $urandom_range(0, 3) == 0 ? 16'hFFFF : 16'($urandom);
      o  = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: c = 16'h0000;
        1: c = 16'hFFFF;
        default: c = 16'($urandom);
      endcase
      step(tag_of(st, o), st, sm, o, c, PCW'($urandom), PCW'($urandom));
    end

    @(negedge clk); op = 2'd0; thr_start = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule